// File: doc/BRIEF.md
# Data Watchpoint Comparator

This block is one hardware watchpoint for a processor's data side. Software programs an address register and a control register. The block then compares every data-memory access with that setting and raises a one-cycle hit when the access matches. The address register holds a word-aligned address. The control register holds four things: an enable, a filter on privilege, a filter on access direction, and an eight-bit mask that picks individual bytes in an eight-byte window.

Each access arrives with its address, its size (byte to doubleword) and its direction. It also carries a swap flag, an exclusive flag and its own privilege attribute. The block works out which byte lanes of the aligned doubleword the access touches. It then tests those lanes against the lanes the mask selects, and applies the two filters. The result is registered, so the hit appears on the clock after the access.

Top module: `wpt_match_unit`

## Requirements
- R1: After reset the hit output is low and both registers read back zero, so the enable (control bit 0) is clear.
- R2: The address register (select 0) stores write data bits [31:2] and always reads bits [1:0] as zero. The control register (select 1) stores bits [12:0] and reads zero above them.
- R3: When control bit 0 is clear, no access ever produces a hit.
- R4: When the byte mask (control bits [12:5]) is all zero, no access produces a hit, even with the enable set.
- R5: Mask bit i, for i from 0 to 3, watches the byte at (address register with bits [1:0] cleared) + i.
- R6: Mask bit i, for i from 4 to 7, watches the byte at (address register with bits [2:0] cleared) + i.
- R7: Access size code 0, 1, 2 and 3 means 1, 2, 4 and 8 bytes. The access starts at its address, and any bytes past the end of its aligned doubleword are dropped. It hits when any byte it touches is a watched byte.
- R8: The direction filter (control bits [4:3]) hits on loads when it is 01, on stores when it is 10, and on both when it is 11. The value 00 never hits. The acc_store input is 1 for a store.
- R9: A swap access passes every nonzero direction setting. The exclusive flag does not change the filtering, so a store-exclusive passes 10 and 11.
- R10: The privilege filter (control bits [2:1]) passes privileged accesses (acc_priv=1) when it is 01, and unprivileged accesses when it is 10. The value 11 passes both, and 00 never hits. Only the access's own attribute is used.
- R11: The hit is high for exactly the one cycle that follows a matching access cycle, and never follows a cycle without acc_valid.
- R12: A register write made in the same cycle as an access does not affect that access. It does affect every access from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 address, 1 control |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 1 | Read target: 0 address, 1 control |
| reg_rd_data | output | 32 | Combinational read data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 doubleword |
| acc_store | input | 1 | 1 store, 0 load |
| acc_swap | input | 1 | Access is a swap |
| acc_excl | input | 1 | Access is exclusive |
| acc_priv | input | 1 | 1 privileged access |
| hit | output | 1 | Registered watchpoint hit pulse |

## Verification
The hit is due one clock after the access cycle. The bench samples it at the falling edge that follows that clock. It drops acc_valid at the same falling edge, so the next falling edge must show the hit low again. Register writes finish on one rising edge. Read data is combinational, so it is checked at the falling edge after the write. In the R12 case, the access and the write are applied at the same falling edge. The bench then expects the old setting's result after one clock and the new setting's result after two.

// File: rtl/wpt_pkg.sv
// Package: shared control-register type and constants for the watchpoint.
// Assumes an eight-lane (doubleword) byte window and a 32-bit data path.
package wpt_pkg;
    localparam int LANES  = 8;
    localparam int CTRL_W = 13;

    // Packed MSB-first so that bas sits at [12:5], dir at [4:3], prv at [2:1], en at [0].
    typedef struct packed {
        logic [LANES-1:0] bas;
        logic [1:0]       dir;
        logic [1:0]       prv;
        logic             en;
    } wpt_ctrl_t;
endpackage

// File: rtl/wpt_regs.sv
// Module: software-visible address and control registers with read mux.
// Assumes a single write port; address bits [1:0] are not stored.
module wpt_regs
    import wpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    output logic [ADDR_W-1:0] value_q,
    output wpt_ctrl_t         ctrl_q
);
    localparam int PAD_W = ADDR_W - CTRL_W;

    // Address register: upper bits writable, low two bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= '0;
        else if (wr_en && !wr_sel)
            value_q <= {wr_data[ADDR_W-1:2], 2'b00};
    end

    // Control register: low CTRL_W bits writable, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_sel)
            ctrl_q <= wpt_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // Read multiplexer, zero-extends the control register.
    always_comb begin
        if (rd_sel)
            rd_data = {{PAD_W{1'b0}}, ctrl_q};
        else
            rd_data = value_q;
    end

    // R2
    value_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && !wr_sel) |-> (value_q[1:0] == 2'b00));
endmodule

// File: rtl/wpt_lane_gen.sv
// Module: converts an access offset and size code into the set of byte lanes
// it touches within its aligned doubleword. Bytes past lane 7 are dropped.
module wpt_lane_gen #(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int SUM_W = OFF_W + 2
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    output logic [LANES-1:0] lanes
);
    logic [SUM_W-1:0] nbytes;
    logic [SUM_W-1:0] first;
    logic [SUM_W-1:0] last_excl;

    // Byte count and exclusive end lane of the access.
    always_comb begin
        nbytes    = SUM_W'(1) << size;
        first     = SUM_W'(offset);
        last_excl = first + nbytes;
    end

    // One comparator pair per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes[i] = (SUM_W'(i) >= first) && (SUM_W'(i) < last_excl);
    end
endmodule

// File: rtl/wpt_filter.sv
// Module: access-direction and privilege qualification. Reserved encodings
// (00) pass nothing because no bit of the field is set.
module wpt_filter (
    input  logic [1:0] dir,
    input  logic [1:0] prv,
    input  logic       is_store,
    input  logic       is_swap,
    input  logic       is_priv,
    output logic       pass
);
    logic as_load;
    logic as_store;
    logic dir_ok;
    logic prv_ok;

    // A swap counts as both a load and a store.
    always_comb begin
        as_load  = !is_store || is_swap;
        as_store =  is_store || is_swap;
        dir_ok   = (dir[0] && as_load) || (dir[1] && as_store);
        prv_ok   = (prv[0] && is_priv) || (prv[1] && !is_priv);
        pass     = dir_ok && prv_ok;
    end
endmodule

// File: rtl/wpt_match_unit.sv
// Module: single data watchpoint. Combines the registers, the access lane
// generator and the filters, and registers the hit one clock after the access.
// Assumes the register contents sampled on the access cycle decide that access.
module wpt_match_unit
    import wpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int OFF_W = $clog2(LANES),
    localparam int HALF  = LANES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic              reg_rd_sel,
    output logic [ADDR_W-1:0] reg_rd_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_store,
    input  logic              acc_swap,
    input  logic              acc_excl,
    input  logic              acc_priv,
    output logic              hit
);
    logic [ADDR_W-1:0] value_q;
    wpt_ctrl_t         ctrl_q;
    logic [LANES-1:0]  acc_lanes;
    logic [LANES-1:0]  watch_lanes;
    logic              same_dword;
    logic              overlap;
    logic              filt_pass;
    logic              hit_d;

    wpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .rd_sel  (reg_rd_sel),
        .rd_data (reg_rd_data),
        .value_q (value_q),
        .ctrl_q  (ctrl_q)
    );

    wpt_lane_gen #(.LANES(LANES)) u_lanes (
        .offset (acc_addr[OFF_W-1:0]),
        .size   (acc_size),
        .lanes  (acc_lanes)
    );

    wpt_filter u_filter (
        .dir      (ctrl_q.dir),
        .prv      (ctrl_q.prv),
        .is_store (acc_store),
        .is_swap  (acc_swap),
        .is_priv  (acc_priv),
        .pass     (filt_pass)
    );

    // Fold low mask half onto the upper lanes when the address sits in the upper word.
    for (genvar i = 0; i < HALF; i++) begin : g_watch
        assign watch_lanes[i]      = ctrl_q.bas[i] && !value_q[OFF_W-1];
        assign watch_lanes[i+HALF] = ctrl_q.bas[i+HALF] ||
                                     (ctrl_q.bas[i] && value_q[OFF_W-1]);
    end

    // Doubleword compare and lane overlap.
    always_comb begin
        same_dword = (acc_addr[ADDR_W-1:OFF_W] == value_q[ADDR_W-1:OFF_W]);
        overlap    = same_dword && |(watch_lanes & acc_lanes);
        hit_d      = acc_valid && ctrl_q.en && filt_pass && overlap;
    end

    // Hit register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hit <= 1'b0;
        else
            hit <= hit_d;
    end

    // R3
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(ctrl_q.en));
    // R4
    hit_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(ctrl_q.bas != '0));
    // R8
    hit_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(ctrl_q.dir != 2'b00));
    // R10
    priv_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $past(ctrl_q.prv == 2'b01)) |-> $past(acc_priv));
    // R11
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(acc_valid));
    // R9
    store_excl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_excl && acc_store && ctrl_q.en && ctrl_q.dir == 2'b10 &&
         ctrl_q.prv == 2'b11 && overlap) |=> hit);
endmodule

// File: tb/wpt_match_unit_test.sv
// Bench: sweeps address, size and mask over a small window, and all filter
// encodings, against an arithmetic byte-address model.
module wpt_match_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_sel = 1'b0;
    logic [31:0] reg_rd_data;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_store = 1'b0;
    logic        acc_swap = 1'b0;
    logic        acc_excl = 1'b0;
    logic        acc_priv = 1'b0;
    logic        hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    wpt_match_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_store(acc_store), .acc_swap(acc_swap), .acc_excl(acc_excl),
        .acc_priv(acc_priv), .hit(hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model: compares absolute byte addresses of watched and accessed bytes.
    function automatic bit model(input logic [31:0] v, input logic [12:0] c,
                                 input logic [31:0] a, input int sz, input bit st,
                                 input bit sw, input bit pr);
        bit ld_ok, pv_ok;
        bit as_ld = !st || sw;
        bit as_st = st || sw;
        if (!c[0]) return 1'b0;
        case (c[4:3])
            2'b01: ld_ok = as_ld;
            2'b10: ld_ok = as_st;
            2'b11: ld_ok = 1'b1;
            default: ld_ok = 1'b0;
        endcase
        case (c[2:1])
            2'b01: pv_ok = pr;
            2'b10: pv_ok = !pr;
            2'b11: pv_ok = 1'b1;
            default: pv_ok = 1'b0;
        endcase
        if (!(ld_ok && pv_ok)) return 1'b0;
        for (int k = 0; k < (1 << sz); k++) begin
            if ((a % 8) + k >= 8) break;
            for (int i = 0; i < 8; i++) begin
                if (c[5+i]) begin
                    logic [31:0] wb;
                    wb = (i < 4) ? (v & 32'hFFFF_FFFC) + i : (v & 32'hFFFF_FFF8) + i;
                    if (wb == a + k) return 1'b1;
                end
            end
        end
        return 1'b0;
    endfunction

    task automatic wr(input bit sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Present one access, check the hit one clock later and its drop after that.
    task automatic acc(input logic [31:0] a, input int sz, input bit st, input bit sw,
                       input bit ex, input bit pr, input bit exp, input string req);
        acc_valid = 1'b1; acc_addr = a; acc_size = 2'(sz);
        acc_store = st; acc_swap = sw; acc_excl = ex; acc_priv = pr;
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
        chk(hit === exp, req, {31'b0, hit}, {31'b0, exp});
        @(posedge clk); @(negedge clk);
        chk(hit === 1'b0, "R11 pulse width", {31'b0, hit}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  masks [11];
        logic [31:0] vals  [2];
        logic [12:0] c;
        masks = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'hFF, 8'h81};
        vals  = '{32'h0000_1003, 32'h0000_1005};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(hit === 1'b0, "R1 hit", {31'b0, hit}, 32'd0);
        reg_rd_sel = 1'b1; #1;
        chk(reg_rd_data === 32'd0, "R1 ctrl", reg_rd_data, 32'd0);
        reg_rd_sel = 1'b0; #1;
        chk(reg_rd_data === 32'd0, "R1 value", reg_rd_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: readback masking
        wr(1'b0, 32'hDEAD_BEEF);
        reg_rd_sel = 1'b0; #1;
        chk(reg_rd_data === 32'hDEAD_BEEC, "R2 value", reg_rd_data, 32'hDEAD_BEEC);
        wr(1'b1, 32'hFFFF_FFFF);
        reg_rd_sel = 1'b1; #1;
        chk(reg_rd_data === 32'h0000_1FFF, "R2 ctrl", reg_rd_data, 32'h0000_1FFF);
        @(negedge clk);

        // R5 R6 R7 R4: lane sweep with filters open
        foreach (vals[vi]) begin
            wr(1'b0, vals[vi]);
            foreach (masks[mi]) begin
                c = {masks[mi], 2'b11, 2'b11, 1'b1};
                wr(1'b1, {19'b0, c});
                for (int a = 32'h0FF8; a < 32'h1010; a++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        acc(a, sz, 1'b0, 1'b0, 1'b0, 1'b1,
                            model(vals[vi], c, a, sz, 1'b0, 1'b0, 1'b1),
                            masks[mi] == 0 ? "R4 zero mask" :
                            (masks[mi][3:0] != 0 ? "R5 R7 low lanes" : "R6 R7 high lanes"));
                    end
                end
            end
        end

        // R3 R8 R9 R10: filter sweep on one watched word
        wr(1'b0, 32'h0000_2000);
        for (int en = 0; en < 2; en++)
            for (int pv = 0; pv < 4; pv++)
                for (int ls = 0; ls < 4; ls++) begin
                    c = {8'hFF, 2'(ls), 2'(pv), 1'(en)};
                    wr(1'b1, {19'b0, c});
                    for (int t = 0; t < 16; t++) begin
                        bit st = t[0], sw = t[1], ex = t[2], pr = t[3];
                        acc(32'h2000, 2, st, sw, ex, pr,
                            model(32'h2000, c, 32'h2000, 2, st, sw, pr),
                            en == 0 ? "R3 disabled" :
                            (sw ? "R9 swap" : (ex ? "R9 exclusive" :
                            (pv != 3 ? "R10 privilege" : "R8 direction"))));
                    end
                end

        // R12: same-cycle write vs access
        wr(1'b1, {19'b0, 8'hFF, 2'b11, 2'b11, 1'b1});
        acc_valid = 1'b1; acc_addr = 32'h2000; acc_size = 2'd0;
        acc_store = 1'b0; acc_swap = 1'b0; acc_excl = 1'b0; acc_priv = 1'b0;
        reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wr_data = 32'd0;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0;
        chk(hit === 1'b1, "R12 old setting", {31'b0, hit}, 32'd1);
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
        chk(hit === 1'b0, "R12 new setting", {31'b0, hit}, 32'd0);
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule